// File: doc/BRIEF.md
# Threshold Interrupt with Persistence Filter

This block sits behind an ambient light measurement path. Every time a new sample arrives with its valid strobe, the block compares it against a programmable upper and lower limit. A sample counts as an excursion only when it lies outside that window. The block raises its threshold flag only after a programmed number of consecutive excursions. This keeps single noisy readings from disturbing the host.

The block holds a two-bit interrupt status word. The word has a threshold flag and a power-on flag, and the power-on flag comes up with every reset so the host can tell that a supply glitch restarted the part. Both flags drive an active-low interrupt line. The host reads the status word with a one-cycle read strobe, which clears it. Dropping the threshold interrupt enable also clears the threshold flag and holds the persistence filter idle.

Top module: `thr_persist_irq`

## Requirements
- R1: After reset, `status_o` reads 2'b10. Bit 1 is the power-on flag and bit 0 is the threshold flag. Once the power-on flag has cleared, it never sets again without a new reset.
- R2: A sample is an excursion only when it is strictly greater than `thr_hi_i` or strictly less than `thr_lo_i`. A sample equal to either limit is inside the window.
- R3: With `irq_en_i` high, the threshold flag sets on the clock edge that takes the (`persist_i`+1)-th consecutive valid excursion. So with `persist_i`=0, a single excursion sets the flag. Cycles with `sample_valid_i` low neither advance nor reset the count.
- R4: A valid sample inside the window returns the consecutive count to zero.
- R5: The edge on which the flag sets also restarts the count. A further trigger needs another `persist_i`+1 consecutive excursions.
- R6: A cycle with `stat_rd_i` high clears both status bits on the next edge.
- R7: If a trigger lands in the same cycle as a status read, the threshold flag stays set, while the power-on flag still clears.
- R8: While `irq_en_i` is low, the threshold flag is cleared on the next edge and held clear, and the count is held at zero, so samples are ignored.
- R9: `int_no` is low exactly when at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | Ambient measurement value |
| sample_valid_i | input | 1 | Marks `sample_i` as a new sample this cycle |
| thr_hi_i | input | DATA_W | Upper window limit |
| thr_lo_i | input | DATA_W | Lower window limit |
| persist_i | input | PERSIST_W | Extra consecutive excursions required before triggering |
| irq_en_i | input | 1 | Threshold interrupt enable |
| stat_rd_i | input | 1 | Status read strobe; clears the status word |
| status_o | output | 2 | {power-on flag, threshold flag} |
| int_no | output | 1 | Interrupt output, active low |

## Verification
The bench builds the block with DATA_W=3 and PERSIST_W=2. With these values it can sweep every pair of limits, every persistence setting and every sample value. This reaches all of the edge cases: samples equal to a limit, inverted windows where the lower limit is above the upper, and persistence settings from immediate firing to four samples. A behavioural model in the bench predicts the status word and interrupt level on every cycle of the sweep. Directed sequences cover a broken run of excursions, a read on the triggering edge, invalid cycles, and a disable while the flag is set.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;
  localparam int STAT_W = 2;

  // bit 1: power-on, bit 0: threshold
  typedef struct packed {
    logic pwr;
    logic thr;
  } irq_stat_t;
endpackage

// File: rtl/window_cmp.sv
module window_cmp #(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  output logic              out_o
);
  logic above, below;

  always_comb begin
    above = sample_i > hi_i;
    below = sample_i < lo_i;
    out_o = above | below;
  end
endmodule

// File: rtl/persist_cnt.sv
module persist_cnt #(
  parameter int PERSIST_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 valid_i,
  input  logic                 out_i,
  input  logic [PERSIST_W-1:0] limit_i,
  output logic                 fire_o
);
  logic [PERSIST_W-1:0] cnt_q;
  logic [PERSIST_W-1:0] cnt_d;

  // >= so a lowered limit mid-run fires at once
  assign fire_o = en_i & valid_i & out_i & (cnt_q >= limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                 cnt_d = '0;
    else if (valid_i && !out_i) cnt_d = '0;
    else if (fire_o)           cnt_d = '0;
    else if (valid_i)          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R4: an in-window sample empties the run
  p_cnt_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && valid_i && !out_i) |=> (cnt_q == '0));

  // R8: disabled filter stays idle
  p_cnt_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));

  // R5: a trigger restarts the run
  p_cnt_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> (cnt_q == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status
  import thr_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      set_i,
  input  logic      rd_i,
  output irq_stat_t stat_o
);
  irq_stat_t stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q.pwr <= 1'b1;
      stat_q.thr <= 1'b0;
    end else begin
      if (rd_i) stat_q.pwr <= 1'b0;
      // set beats read so a coincident event survives
      if (!en_i)      stat_q.thr <= 1'b0;
      else if (set_i) stat_q.thr <= 1'b1;
      else if (rd_i)  stat_q.thr <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  p_pwr_no_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_q.pwr |=> !stat_q.pwr);

  p_read_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !set_i) |=> (!stat_q.thr && !stat_q.pwr));

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && set_i) |=> stat_q.thr);

  p_dis_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !stat_q.thr);
endmodule

// File: rtl/thr_persist_irq.sv
module thr_persist_irq
  import thr_irq_pkg::*;
#(
  parameter int DATA_W    = 14,
  parameter int PERSIST_W = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    sample_i,
  input  logic                 sample_valid_i,
  input  logic [DATA_W-1:0]    thr_hi_i,
  input  logic [DATA_W-1:0]    thr_lo_i,
  input  logic [PERSIST_W-1:0] persist_i,
  input  logic                 irq_en_i,
  input  logic                 stat_rd_i,
  output logic [STAT_W-1:0]    status_o,
  output logic                 int_no
);
  logic      out_win;
  logic      fire;
  irq_stat_t stat;

  window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample_i (sample_i),
    .hi_i     (thr_hi_i),
    .lo_i     (thr_lo_i),
    .out_o    (out_win)
  );

  persist_cnt #(.PERSIST_W(PERSIST_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (irq_en_i),
    .valid_i (sample_valid_i),
    .out_i   (out_win),
    .limit_i (persist_i),
    .fire_o  (fire)
  );

  irq_status u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (irq_en_i),
    .set_i  (fire),
    .rd_i   (stat_rd_i),
    .stat_o (stat)
  );

  assign status_o = stat;
  assign int_no   = ~(stat.pwr | stat.thr);

  // R3: threshold flag only rises after an enabled valid sample
  p_rise_needs_sample_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[0]) |-> $past(sample_valid_i && irq_en_i));
endmodule

// File: tb/tb_thr_persist_irq.sv
module tb_thr_persist_irq;
  localparam int DW = 3;
  localparam int PW = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          sample_valid_i = 1'b0;
  logic [DW-1:0] thr_hi_i = '0;
  logic [DW-1:0] thr_lo_i = '0;
  logic [PW-1:0] persist_i = '0;
  logic          irq_en_i = 1'b0;
  logic          stat_rd_i = 1'b0;
  logic [1:0]    status_o;
  logic          int_no;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_cnt = 0;
  bit m_thr = 0;
  bit m_pwr = 1;

  always #5 clk_i = ~clk_i;

  thr_persist_irq #(.DATA_W(DW), .PERSIST_W(PW)) dut (
    .clk_i, .rst_ni, .sample_i, .sample_valid_i, .thr_hi_i, .thr_lo_i,
    .persist_i, .irq_en_i, .stat_rd_i, .status_o, .int_no
  );

  task automatic chk(input logic [1:0] exp_st, input string tag);
    total++;
    if (status_o !== exp_st || int_no !== ~(exp_st[0] | exp_st[1])) begin
      bad++;
      $display("FAIL %s: status=%b int_no=%b expected status=%b int_no=%b",
               tag, status_o, int_no, exp_st, ~(exp_st[0] | exp_st[1]));
    end
  endtask

  // one clock: drive, advance model, check after the edge
  task automatic cyc(input int s, input bit v, input bit rd, input string tag);
    bit out, fire;
    sample_i = DW'(s);
    sample_valid_i = v;
    stat_rd_i = rd;
    out  = (s > int'(thr_hi_i)) || (s < int'(thr_lo_i));
    fire = irq_en_i && v && out && (m_cnt >= int'(persist_i));
    if (!irq_en_i)  m_cnt = 0;
    else if (v && !out) m_cnt = 0;
    else if (fire)  m_cnt = 0;
    else if (v)     m_cnt = m_cnt + 1;
    if (!irq_en_i)  m_thr = 0;
    else if (fire)  m_thr = 1;
    else if (rd)    m_thr = 0;
    if (rd) m_pwr = 0;
    @(posedge clk_i);
    #1;
    sample_valid_i = 1'b0;
    stat_rd_i = 1'b0;
    chk({m_pwr, m_thr}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk(2'b10, "R1 reset value");
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk(2'b10, "R1 held after release, R9 int low");

    thr_hi_i = 3'd5; thr_lo_i = 3'd2; persist_i = 2'd2; irq_en_i = 1'b1;
    cyc(0, 0, 1, "R6 read clears power-on");
    chk(2'b00, "R9 int high when clear");
    cyc(0, 0, 0, "R1 power-on stays clear");

    // R2: limits themselves are inside
    cyc(5, 1, 0, "R2 equal upper"); cyc(5, 1, 0, "R2 equal upper");
    cyc(2, 1, 0, "R2 equal lower"); cyc(2, 1, 0, "R2 equal lower");
    chk(2'b00, "R2 no trigger at limits");
    // R3: persist 2 -> third excursion
    cyc(6, 1, 0, "R3 first"); cyc(1, 1, 0, "R3 second");
    chk(2'b00, "R3 not yet after two");
    cyc(7, 0, 0, "R3 invalid ignored"); cyc(3, 0, 0, "R3 invalid ignored");
    cyc(7, 1, 0, "R3 third");
    chk(2'b01, "R3 fires on third excursion");
    cyc(0, 0, 1, "R6 read clears threshold");
    chk(2'b00, "R6 cleared");
    // R4: broken run
    cyc(6, 1, 0, "R4"); cyc(6, 1, 0, "R4"); cyc(4, 1, 0, "R4 inside");
    cyc(6, 1, 0, "R4"); cyc(6, 1, 0, "R4");
    chk(2'b00, "R4 run restarted");
    cyc(6, 1, 0, "R4 completes");
    chk(2'b01, "R4 fires after fresh run");
    // R5: restart after trigger
    cyc(6, 1, 1, "R5 read");
    cyc(6, 1, 0, "R5");
    chk(2'b00, "R5 needs full run again");
    cyc(6, 1, 0, "R5 completes");
    chk(2'b01, "R5 second trigger");
    // R7: trigger coincident with read
    cyc(0, 0, 1, "R7 pre-clear");
    cyc(6, 1, 0, "R7"); cyc(6, 1, 0, "R7");
    cyc(6, 1, 1, "R7 trigger with read");
    chk(2'b01, "R7 flag survives read");
    // R8: disable
    irq_en_i = 1'b0;
    cyc(6, 1, 0, "R8 disable clears");
    chk(2'b00, "R8 cleared by disable");
    for (int i = 0; i < 6; i++) cyc(7, 1, 0, "R8 samples ignored");
    chk(2'b00, "R8 still clear");
    irq_en_i = 1'b1;
    cyc(7, 1, 0, "R8 re-enable"); cyc(7, 1, 0, "R8 re-enable");
    chk(2'b00, "R8 count was held at zero");
    cyc(7, 1, 0, "R8 re-enable completes");
    chk(2'b01, "R8 fires after full run");

    // sweep: every window, persist and sample value
    for (int hi = 0; hi < 8; hi++)
      for (int lo = 0; lo < 8; lo++)
        for (int p = 0; p < 4; p++) begin
          thr_hi_i = DW'(hi); thr_lo_i = DW'(lo); persist_i = PW'(p);
          irq_en_i = ((hi + lo + p) % 7) != 0;
          cyc(0, 0, 1, "R6 sweep clear");
          for (int s = 0; s < 8; s++)
            for (int r = 0; r < 3; r++)
              cyc(s, (r != 1) || (s[0]), (r == 2) && (s == 4), "R2 R3 R4 R5 R7 R8 sweep");
        end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule